// File: doc/BRIEF.md
# Double-Buffered Serial DMA Channel

This block is a pair of DMA channels, one for each direction of a serial peripheral. The transmit channel reads elements from memory and hands them to the peripheral whenever its transmit holding register is free. The receive channel takes each element the peripheral has captured and writes it to memory. Each direction has an active pointer and element count and a queued pointer and count. When the active count runs out, the queued pair takes its place in the same clock, so a second buffer follows the first without a gap and without any help from the processor.

Software sets up the channel through a small word-addressed register port. It loads the pointers and counts, then turns each direction on or off through a control word. It watches four flags: a per-direction end-of-buffer flag and a per-direction flag that says both buffers of that direction are used up. Any of these flags can be routed to one interrupt line. Elements are either narrow (8 bits, stored one per byte address) or wide (16 bits, stored at every second byte address). An input pin selects the size. The counts always count elements and never bytes.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After synchronous reset all pointers and counts read zero, both directions are off, `stat_flags` reads 4'hF, `irq`, `mem_req`, `per_tx_load` and `per_rx_take` are low.
- R2: The active and queued pointer/count registers read back what was written. The receive set is at word addresses 0 (pointer), 1 (count), 4 (queued pointer) and 5 (queued count). The transmit set is at 2, 3, 6 and 7. Counts are 16 bits wide and zero-extended on read.
- R3: With transmit on and a nonzero transmit count, elements are fetched from memory at the transmit pointer and presented on `per_tx_data` with a one-cycle `per_tx_load` pulse, in address order. The pointer steps by 2 bytes when `wide_elem` is 1 and by 1 when it is 0. In narrow mode bits 15:8 of the presented element are zero.
- R4: With receive on, a nonzero receive count and `per_rx_full` high, the element on `per_rx_data` is taken with a one-cycle `per_rx_take` pulse and written to memory at the receive pointer, with the same stepping. In narrow mode bits 15:8 of the written word are zero.
- R5: When an active count reaches zero while the queued count is nonzero, the queued pointer and count move into the active registers in that same cycle and the queued count becomes zero. An idle direction whose active count is zero picks up a nonzero queued count the same way.
- R6: `stat_flags[0]` (receive end) and `stat_flags[1]` (transmit end) set when the active count of that direction reaches zero. They clear when a nonzero value is written to that active count, and they set when zero is written to it.
- R7: `stat_flags[2]` is set exactly when both receive counts are zero. `stat_flags[3]` is set exactly when both transmit counts are zero.
- R8: Control word address 8: bit 0 turns receive on, bit 1 turns it off, bit 8 turns transmit on, bit 9 turns it off. When the on and off bits of one direction are written together, the direction goes off. Address 9 reads the on state of receive in bit 0 and of transmit in bit 8.
- R9: A direction whose active and queued counts are zero makes no memory request and takes no element, even when it is on.
- R10: A memory request holds `mem_req`, `mem_we` and `mem_addr` steady until `mem_ack` is seen.
- R11: Address 10 reads the flags in bits 7:4. Address 11 holds an interrupt mask in bits 7:4, aligned to the same flags. `irq` is high exactly when a set flag has its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_elem | input | 1 | 1: 16-bit elements, 2-byte stride; 0: 8-bit elements, 1-byte stride |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the address |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write (receive), 0 = read (transmit) |
| mem_addr | output | 32 | Byte address of the element |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid with it |
| mem_rdata | input | 16 | Read data |
| per_tx_ready | input | 1 | Peripheral transmit holding register is empty |
| per_tx_load | output | 1 | One-cycle strobe loading `per_tx_data` into the peripheral |
| per_tx_data | output | 16 | Element for the peripheral |
| per_rx_full | input | 1 | Peripheral holds a received element |
| per_rx_data | input | 16 | Received element |
| per_rx_take | output | 1 | One-cycle strobe that takes the received element |
| stat_flags | output | 4 | {tx both empty, rx both empty, tx end, rx end} |
| irq | output | 1 | Masked OR of the flags |

## Verification
A corrupted pointer or count shows up at the peripheral or memory ports within a few elements. The data arrives from or lands at the wrong address, the number of load or take strobes differs from the programmed total, or the final pointer read back does not match. A fault in the queued-buffer reload shows up as a missing or repeated second buffer, or as a queued count that reads nonzero after completion. A wrong flag or control bit shows up on `stat_flags`, on `irq` or on the control read-back two cycles after the write that should have changed it.

// File: rtl/dbd_pkg.sv
package dbd_pkg;
  // register word addresses
  localparam int RA_RX_PTR  = 0;
  localparam int RA_RX_CNT  = 1;
  localparam int RA_TX_PTR  = 2;
  localparam int RA_TX_CNT  = 3;
  localparam int RA_RX_NPTR = 4;
  localparam int RA_RX_NCNT = 5;
  localparam int RA_TX_NPTR = 6;
  localparam int RA_TX_NCNT = 7;
  localparam int RA_CTRL    = 8;
  localparam int RA_ONSTATE = 9;
  localparam int RA_STAT    = 10;
  localparam int RA_IMASK   = 11;

  // control word bits
  localparam int CB_RX_ON  = 0;
  localparam int CB_RX_OFF = 1;
  localparam int CB_TX_ON  = 8;
  localparam int CB_TX_OFF = 9;

  // flag field position in status and mask words
  localparam int FLAG_LSB = 4;
  localparam int NFLAGS   = 4;

  // direction index
  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;
  localparam int NDIR   = 2;

  typedef enum logic [1:0] {TX_IDLE, TX_FETCH, TX_PUSH} tx_st_e;
  typedef enum logic [0:0] {RX_IDLE, RX_STORE} rx_st_e;
endpackage

// File: rtl/dbd_buf_pair.sv
module dbd_buf_pair #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wide,
  input  logic          set_ptr,
  input  logic          set_cnt,
  input  logic          set_nptr,
  input  logic          set_ncnt,
  input  logic [RW-1:0] wdata,
  input  logic          step,
  output logic [AW-1:0] cur_ptr,
  output logic [CW-1:0] cur_cnt,
  output logic [AW-1:0] nxt_ptr,
  output logic [CW-1:0] nxt_cnt,
  output logic          end_flag
);
  logic [AW-1:0] stride;
  logic          last_elem;
  logic          nxt_ready;

  assign stride    = wide ? AW'(2) : AW'(1);
  assign last_elem = (cur_cnt == CW'(1));
  assign nxt_ready = (nxt_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_ptr  <= '0;
      cur_cnt  <= '0;
      nxt_ptr  <= '0;
      nxt_cnt  <= '0;
      end_flag <= 1'b1;
    end else begin
      if (step && cur_cnt != '0) begin
        if (last_elem) begin
          end_flag <= 1'b1;
          if (nxt_ready) begin
            cur_ptr <= nxt_ptr;
            cur_cnt <= nxt_cnt;
            nxt_cnt <= '0;
          end else begin
            cur_ptr <= cur_ptr + stride;
            cur_cnt <= '0;
          end
        end else begin
          cur_ptr <= cur_ptr + stride;
          cur_cnt <= cur_cnt - CW'(1);
        end
      end else if (cur_cnt == '0 && nxt_ready) begin
        cur_ptr <= nxt_ptr;
        cur_cnt <= nxt_cnt;
        nxt_cnt <= '0;
      end
      // register writes take precedence over engine updates
      if (set_ptr)  cur_ptr <= wdata[AW-1:0];
      if (set_cnt) begin
        cur_cnt  <= wdata[CW-1:0];
        end_flag <= (wdata[CW-1:0] == '0);
      end
      if (set_nptr) nxt_ptr <= wdata[AW-1:0];
      if (set_ncnt) nxt_cnt <= wdata[CW-1:0];
    end
  end
endmodule

// File: rtl/dbd_tx_engine.sv
module dbd_tx_engine
  import dbd_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wide,
  input  logic          cnt_nz,
  input  logic [AW-1:0] ptr,
  output logic          mreq,
  output logic [AW-1:0] maddr,
  input  logic          mack,
  input  logic [DW-1:0] mrdata,
  input  logic          per_ready,
  output logic          per_load,
  output logic [DW-1:0] per_data,
  output logic          step
);
  localparam int NW = DW / 2;

  tx_st_e        st;
  logic [DW-1:0] hold;

  assign mreq  = (st == TX_FETCH);
  assign maddr = ptr;
  assign step  = (st == TX_PUSH) && per_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= TX_IDLE;
      hold     <= '0;
      per_load <= 1'b0;
      per_data <= '0;
    end else begin
      per_load <= 1'b0;
      case (st)
        TX_IDLE:  if (en && cnt_nz) st <= TX_FETCH;
        TX_FETCH: if (mack) begin
          hold <= wide ? mrdata : {{(DW-NW){1'b0}}, mrdata[NW-1:0]};
          st   <= TX_PUSH;
        end
        TX_PUSH:  if (per_ready) begin
          per_load <= 1'b1;
          per_data <= hold;
          st       <= TX_IDLE;
        end
        default:  st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbd_rx_engine.sv
module dbd_rx_engine
  import dbd_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wide,
  input  logic          cnt_nz,
  input  logic [AW-1:0] ptr,
  output logic          mreq,
  output logic [AW-1:0] maddr,
  output logic [DW-1:0] mwdata,
  input  logic          mack,
  input  logic          per_full,
  input  logic [DW-1:0] per_data,
  output logic          per_take,
  output logic          step
);
  localparam int NW = DW / 2;

  rx_st_e        st;
  logic [DW-1:0] hold;

  assign mreq   = (st == RX_STORE);
  assign maddr  = ptr;
  assign mwdata = hold;
  assign step   = (st == RX_STORE) && mack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      hold     <= '0;
      per_take <= 1'b0;
    end else begin
      per_take <= 1'b0;
      case (st)
        RX_IDLE: if (en && cnt_nz && per_full) begin
          hold     <= wide ? per_data : {{(DW-NW){1'b0}}, per_data[NW-1:0]};
          per_take <= 1'b1;
          st       <= RX_STORE;
        end
        RX_STORE: if (mack) st <= RX_IDLE;
        default:  st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbd_mem_arb.sv
module dbd_mem_arb #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_req,
  input  logic [AW-1:0] rx_addr,
  input  logic [DW-1:0] rx_wdata,
  output logic          rx_ack,
  input  logic          tx_req,
  input  logic [AW-1:0] tx_addr,
  output logic          tx_ack,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack
);
  logic busy;
  logic own_rx;

  assign rx_ack = busy && own_rx  && mem_ack;
  assign tx_ack = busy && !own_rx && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      own_rx    <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (!busy) begin
      if (rx_req) begin
        busy      <= 1'b1;
        own_rx    <= 1'b1;
        mem_req   <= 1'b1;
        mem_we    <= 1'b1;
        mem_addr  <= rx_addr;
        mem_wdata <= rx_wdata;
      end else if (tx_req) begin
        busy      <= 1'b1;
        own_rx    <= 1'b0;
        mem_req   <= 1'b1;
        mem_we    <= 1'b0;
        mem_addr  <= tx_addr;
      end
    end else if (mem_ack) begin
      busy    <= 1'b0;
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
    end
  end
endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
  import dbd_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int DW   = 16,
  parameter int RW   = 32,
  parameter int RA_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wide_elem,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [RW-1:0]   reg_wdata,
  output logic [RW-1:0]   reg_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ack,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            per_tx_ready,
  output logic            per_tx_load,
  output logic [DW-1:0]   per_tx_data,
  input  logic            per_rx_full,
  input  logic [DW-1:0]   per_rx_data,
  output logic            per_rx_take,
  output logic [NFLAGS-1:0] stat_flags,
  output logic            irq
);
  logic [AW-1:0] cur_ptr [NDIR];
  logic [CW-1:0] cur_cnt [NDIR];
  logic [AW-1:0] nxt_ptr [NDIR];
  logic [CW-1:0] nxt_cnt [NDIR];
  logic [NDIR-1:0] end_flag;
  logic [NDIR-1:0] step;
  logic [NDIR-1:0] all_zero;

  logic rx_on, tx_on;
  logic [NFLAGS-1:0] imask;
  logic [NFLAGS-1:0] flags_next;
  logic [RW-1:0]     rd_next;
  logic ctrl_wr;

  assign ctrl_wr = reg_we && (reg_addr == RA_W'(RA_CTRL));

  // per-direction pointer/count banks
  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    localparam logic [RA_W-1:0] A_PTR  = RA_W'(2 * d);
    localparam logic [RA_W-1:0] A_CNT  = RA_W'(2 * d + 1);
    localparam logic [RA_W-1:0] A_NPTR = RA_W'(4 + 2 * d);
    localparam logic [RA_W-1:0] A_NCNT = RA_W'(5 + 2 * d);

    dbd_buf_pair #(.AW(AW), .CW(CW), .RW(RW)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wide     (wide_elem),
      .set_ptr  (reg_we && reg_addr == A_PTR),
      .set_cnt  (reg_we && reg_addr == A_CNT),
      .set_nptr (reg_we && reg_addr == A_NPTR),
      .set_ncnt (reg_we && reg_addr == A_NCNT),
      .wdata    (reg_wdata),
      .step     (step[d]),
      .cur_ptr  (cur_ptr[d]),
      .cur_cnt  (cur_cnt[d]),
      .nxt_ptr  (nxt_ptr[d]),
      .nxt_cnt  (nxt_cnt[d]),
      .end_flag (end_flag[d])
    );

    assign all_zero[d] = (cur_cnt[d] == '0) && (nxt_cnt[d] == '0);
  end

  // engines and shared memory port
  logic          rx_mreq, tx_mreq, rx_mack, tx_mack;
  logic [AW-1:0] rx_maddr, tx_maddr;
  logic [DW-1:0] rx_mwdata;
  logic          rx_step, tx_step;

  assign step[DIR_RX] = rx_step;
  assign step[DIR_TX] = tx_step;

  dbd_rx_engine #(.AW(AW), .DW(DW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .en       (rx_on),
    .wide     (wide_elem),
    .cnt_nz   (cur_cnt[DIR_RX] != '0),
    .ptr      (cur_ptr[DIR_RX]),
    .mreq     (rx_mreq),
    .maddr    (rx_maddr),
    .mwdata   (rx_mwdata),
    .mack     (rx_mack),
    .per_full (per_rx_full),
    .per_data (per_rx_data),
    .per_take (per_rx_take),
    .step     (rx_step)
  );

  dbd_tx_engine #(.AW(AW), .DW(DW)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .en        (tx_on),
    .wide      (wide_elem),
    .cnt_nz    (cur_cnt[DIR_TX] != '0),
    .ptr       (cur_ptr[DIR_TX]),
    .mreq      (tx_mreq),
    .maddr     (tx_maddr),
    .mack      (tx_mack),
    .mrdata    (mem_rdata),
    .per_ready (per_tx_ready),
    .per_load  (per_tx_load),
    .per_data  (per_tx_data),
    .step      (tx_step)
  );

  dbd_mem_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .rx_req    (rx_mreq),
    .rx_addr   (rx_maddr),
    .rx_wdata  (rx_mwdata),
    .rx_ack    (rx_mack),
    .tx_req    (tx_mreq),
    .tx_addr   (tx_maddr),
    .tx_ack    (tx_mack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
  );

  // control: off beats on when both are written
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_on <= 1'b0;
      tx_on <= 1'b0;
      imask <= '0;
    end else begin
      if (ctrl_wr) begin
        if (reg_wdata[CB_RX_OFF])     rx_on <= 1'b0;
        else if (reg_wdata[CB_RX_ON]) rx_on <= 1'b1;
        if (reg_wdata[CB_TX_OFF])     tx_on <= 1'b0;
        else if (reg_wdata[CB_TX_ON]) tx_on <= 1'b1;
      end
      if (reg_we && reg_addr == RA_W'(RA_IMASK))
        imask <= reg_wdata[FLAG_LSB +: NFLAGS];
    end
  end

  // flags and interrupt
  assign flags_next = {all_zero[DIR_TX], all_zero[DIR_RX],
                       end_flag[DIR_TX], end_flag[DIR_RX]};

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_flags <= '1;
      irq        <= 1'b0;
    end else begin
      stat_flags <= flags_next;
      irq        <= |(flags_next & imask);
    end
  end

  // register read
  always_comb begin
    rd_next = '0;
    case (reg_addr)
      RA_W'(RA_RX_PTR):  rd_next = RW'(cur_ptr[DIR_RX]);
      RA_W'(RA_RX_CNT):  rd_next = RW'(cur_cnt[DIR_RX]);
      RA_W'(RA_TX_PTR):  rd_next = RW'(cur_ptr[DIR_TX]);
      RA_W'(RA_TX_CNT):  rd_next = RW'(cur_cnt[DIR_TX]);
      RA_W'(RA_RX_NPTR): rd_next = RW'(nxt_ptr[DIR_RX]);
      RA_W'(RA_RX_NCNT): rd_next = RW'(nxt_cnt[DIR_RX]);
      RA_W'(RA_TX_NPTR): rd_next = RW'(nxt_ptr[DIR_TX]);
      RA_W'(RA_TX_NCNT): rd_next = RW'(nxt_cnt[DIR_TX]);
      RA_W'(RA_ONSTATE): begin
        rd_next[CB_RX_ON] = rx_on;
        rd_next[CB_TX_ON] = tx_on;
      end
      RA_W'(RA_STAT):    rd_next[FLAG_LSB +: NFLAGS] = stat_flags;
      RA_W'(RA_IMASK):   rd_next[FLAG_LSB +: NFLAGS] = imask;
      default:           rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/dbuf_dma_chan_chk.sv
module dbuf_dma_chan_chk
  import dbd_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int RW   = 32,
  parameter int RA_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            reg_we,
  input logic [RA_W-1:0] reg_addr,
  input logic [RW-1:0]   reg_wdata,
  input logic            mem_req,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic            mem_ack,
  input logic            per_tx_load,
  input logic            per_rx_take,
  input logic            rx_on,
  input logic            tx_on,
  input logic [NFLAGS-1:0] stat_flags
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_load_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    per_tx_load |=> !per_tx_load);

  p_take_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    per_rx_take |=> !per_rx_take);

  p_rx_off_wins_r8: assert property (@(posedge clk) disable iff (rst)
    reg_we && reg_addr == RA_W'(RA_CTRL) && reg_wdata[CB_RX_OFF] |=> !rx_on);

  p_tx_off_wins_r8: assert property (@(posedge clk) disable iff (rst)
    reg_we && reg_addr == RA_W'(RA_CTRL) && reg_wdata[CB_TX_OFF] |=> !tx_on);

  p_end_clear_r6: assert property (@(posedge clk) disable iff (rst)
    reg_we && reg_addr == RA_W'(RA_RX_CNT) && reg_wdata[CW-1:0] != '0
      |=> ##1 !stat_flags[0]);
endmodule

bind dbuf_dma_chan dbuf_dma_chan_chk #(.AW(AW), .CW(CW), .RW(RW), .RA_W(RA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_ack     (mem_ack),
  .per_tx_load (per_tx_load),
  .per_rx_take (per_rx_take),
  .rx_on       (rx_on),
  .tx_on       (tx_on),
  .stat_flags  (stat_flags)
);

// File: tb/tb_dbuf_dma_chan.sv
module tb_dbuf_dma_chan;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst;
  logic        wide_elem;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = 16'h0;
  logic        per_tx_ready;
  logic        per_tx_load;
  logic [15:0] per_tx_data;
  logic        per_rx_full;
  logic [15:0] per_rx_data;
  logic        per_rx_take;
  logic [3:0]  stat_flags;
  logic        irq;

  dbuf_dma_chan dut (
    .clk(clk), .rst(rst), .wide_elem(wide_elem),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .per_tx_ready(per_tx_ready), .per_tx_load(per_tx_load), .per_tx_data(per_tx_data),
    .per_rx_full(per_rx_full), .per_rx_data(per_rx_data), .per_rx_take(per_rx_take),
    .stat_flags(stat_flags), .irq(irq)
  );

  int nchk = 0;
  int nfail = 0;

  function automatic logic [15:0] init_val(int a);
    return 16'(a * 16'h9E37 + 16'h1234);
  endfunction

  // memory and peripheral models
  logic [15:0] mem [0:1023];
  logic [15:0] txlog [0:31];
  logic [15:0] rxq [0:31];
  logic        mem_fill = 1'b0;
  logic        log_clr = 1'b0;
  int txn = 0, rx_idx = 0, rxn = 0, nreq = 0;

  always @(posedge clk) begin
    if (mem_fill) begin
      for (int i = 0; i < 1024; i++) mem[i] <= init_val(i);
      mem_ack <= 1'b0;
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[9:0]];
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (log_clr) begin
      txn <= 0; rx_idx <= 0; nreq <= 0;
    end else begin
      if (per_tx_load) begin txlog[txn[4:0]] <= per_tx_data; txn <= txn + 1; end
      if (per_rx_take) rx_idx <= rx_idx + 1;
      if (mem_req && !mem_ack) nreq <= nreq + 1;
    end
  end

  assign per_rx_full = (rx_idx < rxn);
  assign per_rx_data = rxq[rx_idx[4:0]];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart_logs();
    @(negedge clk); log_clr = 1'b1; mem_fill = 1'b1;
    @(negedge clk); log_clr = 1'b0; mem_fill = 1'b0;
  endtask

  // one full transfer round, both directions
  task automatic run_round(logic wd, int l1, int l2, int lr);
    logic [31:0] v;
    int st;
    logic [15:0] msk;
    st  = wd ? 2 : 1;
    msk = wd ? 16'hFFFF : 16'h00FF;
    wide_elem = wd;
    rxn = 0;
    restart_logs();
    for (int i = 0; i < 32; i++) rxq[i] = 16'($urandom);
    wr(2, 32'h100); wr(3, 32'(l1)); wr(6, 32'h200); wr(7, 32'(l2));
    wr(0, 32'h300); wr(1, 32'(lr));
    rxn = lr;
    wr(8, 32'h101);
    settle(300);
    chk("R3 tx element count", 32'(txn), 32'(l1 + l2));
    for (int k = 0; k < l1; k++)
      chk("R3 tx data first buffer", {16'h0, txlog[k]}, {16'h0, init_val(16'h100 + k*st) & msk});
    for (int k = 0; k < l2; k++)
      chk("R5 tx data queued buffer", {16'h0, txlog[l1+k]}, {16'h0, init_val(16'h200 + k*st) & msk});
    for (int k = 0; k < lr; k++)
      chk("R4 rx data in memory", {16'h0, mem[16'h300 + k*st]}, {16'h0, rxq[k] & msk});
    chk("R4 rx take count", 32'(rx_idx), 32'(lr));
    rd(2, v);
    chk("R5 tx final pointer", v, (l2 > 0) ? 32'(16'h200 + l2*st) : 32'(16'h100 + l1*st));
    rd(7, v); chk("R5 tx queued count cleared", v, 32'h0);
    rd(3, v); chk("R3 tx count exhausted", v, 32'h0);
    rd(0, v); chk("R4 rx final pointer", v, 32'(16'h300 + lr*st));
    chk("R7 R6 flags after round", {28'h0, stat_flags}, 32'hF);
    wr(8, 32'h202);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed));
    rst = 1'b1; wide_elem = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    per_tx_ready = 1'b1;
    restart_logs();
    settle(3);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk("R1 flags", {28'h0, stat_flags}, 32'hF);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 mem_req", {31'h0, mem_req}, 32'h0);
    chk("R1 strobes", {30'h0, per_tx_load, per_rx_take}, 32'h0);
    for (int a = 0; a < 8; a++) begin
      rd(a, v); chk("R1 pointer/count zero", v, 32'h0);
    end
    rd(9, v); chk("R1 both off", v, 32'h0);

    // R2 readback, current counts first so no idle reload occurs
    for (int a = 0; a < 8; a += 2) wr(a, 32'h1000_0000 + 32'(a));
    wr(1, 32'h0001_0011); wr(3, 32'h13);
    wr(5, 32'h15); wr(7, 32'h17);
    for (int a = 0; a < 8; a += 2) begin
      rd(a, v); chk("R2 pointer readback", v, 32'h1000_0000 + 32'(a));
    end
    rd(1, v); chk("R2 count is 16 bits", v, 32'h11);
    rd(3, v); chk("R2 tx count", v, 32'h13);
    rd(5, v); chk("R2 rx queued count", v, 32'h15);
    rd(7, v); chk("R2 tx queued count", v, 32'h17);
    settle(2);
    chk("R6 R7 flags clear after nonzero counts", {28'h0, stat_flags}, 32'h0);
    rd(10, v); chk("R11 status word bits 7:4", v, 32'h0);
    wr(5, 0); wr(7, 0);
    settle(2);
    chk("R7 queued zero, current nonzero", {28'h0, stat_flags}, 32'h0);
    wr(1, 0); wr(3, 0);
    settle(2);
    chk("R6 writing zero sets end flags", {28'h0, stat_flags}, 32'hF);
    rd(10, v); chk("R11 status word", v, 32'hF0);

    // R5 idle reload
    wr(6, 32'h40); wr(7, 32'h3);
    settle(2);
    rd(2, v); chk("R5 idle reload pointer", v, 32'h40);
    rd(3, v); chk("R5 idle reload count", v, 32'h3);
    rd(7, v); chk("R5 queued count cleared", v, 32'h0);
    chk("R7 tx not empty after reload", {31'h0, stat_flags[3]}, 32'h0);
    wr(3, 0);
    settle(2);

    // R8 control priority
    wr(8, 32'h303); rd(9, v); chk("R8 on+off gives off", v, 32'h0);
    wr(8, 32'h101); rd(9, v); chk("R8 both on", v, 32'h101);
    wr(8, 32'h003); rd(9, v); chk("R8 rx off wins", v, 32'h100);
    wr(8, 32'h300); rd(9, v); chk("R8 tx off wins", v, 32'h0);

    // R9 zero counts halt even when on
    restart_logs();
    rxq[0] = 16'hABCD; rxn = 2;
    wr(8, 32'h101);
    settle(30);
    chk("R9 no memory request", 32'(nreq), 32'h0);
    chk("R9 no element taken", 32'(rx_idx), 32'h0);
    wr(8, 32'h202);
    // R8 off direction ignores a waiting element
    wr(1, 32'h2);
    settle(20);
    chk("R8 off rx takes nothing", 32'(rx_idx), 32'h0);
    rd(1, v); chk("R8 rx count untouched", v, 32'h2);
    wr(1, 0);
    rxn = 0;

    // R11 interrupt masking
    settle(2);
    chk("R11 no mask no irq", {31'h0, irq}, 32'h0);
    wr(11, 32'h20);
    settle(2);
    chk("R11 masked tx end raises irq", {31'h0, irq}, 32'h1);
    rd(11, v); chk("R11 mask readback", v, 32'h20);
    wr(3, 32'h5);
    settle(2);
    chk("R11 irq drops when flag clears", {31'h0, irq}, 32'h0);
    wr(3, 0); wr(11, 0);

    // directed rounds then seeded random rounds
    run_round(1'b1, 3, 2, 4);
    run_round(1'b0, 2, 3, 5);
    run_round(1'b1, 1, 0, 1);
    for (int r = 0; r < 6; r++)
      run_round(1'($urandom), 1 + int'($urandom % 4), int'($urandom % 4), 1 + int'($urandom % 5));

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule